// File: doc/BRIEF.md
# Timed Shutdown and Restart Line Sequencer

This block drives a single pad so that a downstream power or reset circuit sees a request. The request works whether that circuit reacts to a level, to a rising edge or to a falling edge. A start pulse launches a three-step pattern on the pad: the line goes active, then inactive, then active again. Each step lasts for a programmed number of milliseconds. After the last active step, a final wait period runs. If the wait expires, the system did not go down, and the block reports a timeout.

A free-running prescaler derives a one-cycle millisecond tick from the clock-frequency parameter. All phase timing counts these ticks. The prescaler is cleared when a start is accepted, so each phase lasts a whole number of milliseconds measured from that start. A polarity input selects whether the active level is high or low. A deferred-drive input keeps the output enable off until the sequence begins. Without it, the pad is driven to its inactive level from reset onward.

Top module: `shutdown_pulse_seq`

## Requirements
- R1: While reset is held and after its release, busy, done and timeout are 0. The pad output enable equals the inverse of the deferred-drive input, and the pad carries the inactive level.
- R2: When the polarity input is 1, the active level is 1 and the inactive level is 0. When it is 0, the active level is 0 and the inactive level is 1.
- R3: A start seen in idle at a clock edge puts the pad at its active level, with the output enable at 1 and busy at 1, from the next cycle on.
- R4: The first active phase lasts max(A,1) milliseconds from start acceptance, where A is the active delay. After it, the pad goes to the inactive level.
- R5: The inactive phase lasts max(I,1) milliseconds, where I is the inactive delay. Then the pad returns to the active level, and done rises in the same cycle.
- R6: The wait phase lasts max(W,1) milliseconds, where W is the wait delay. Then timeout becomes 1 and busy becomes 0. Done stays 1 and the pad stays active with the output enable at 1.
- R7: With deferred drive set, the output enable is 0 throughout idle. With it clear, the output enable is 1 in idle.
- R8: The three delays and the polarity are captured at start acceptance. Changing them during a sequence does not alter its timing or its levels.
- R9: A start is ignored while busy and after timeout. Only reset returns the block to idle, and the pad holds its active level until then.
- R10: A delay value of 0 ends its phase at the first tick, which is one millisecond. The sequence still runs to timeout.
- R11: One millisecond equals CLK_HZ/1000 clock cycles, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch request, accepted only in idle |
| act_high_i | input | 1 | Polarity: 1 makes the active level high |
| defer_oe_i | input | 1 | 1 keeps the pad undriven until start |
| dly_act_i | input | DLY_W | First active phase length in ms |
| dly_inact_i | input | DLY_W | Inactive phase length in ms |
| dly_wait_i | input | DLY_W | Final wait length in ms |
| pad_o | output | 1 | Pad output value |
| pad_oe_o | output | 1 | Pad output enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All three edges have been emitted |
| timeout_o | output | 1 | Wait expired with the system still running |

## Verification
The bench measures each phase length in cycles, including zero delays. A design that waited for a stale, free-running tick would produce a short first phase. A design that treated zero as "never" would hang in the phase. It changes the delays and the polarity in the middle of a sequence, which exposes a design that reads them live. It also pulses start during a run and after timeout, where a design that re-armed would restart the pattern. Reset with deferred drive checks that the enable stays low in idle. The same reset with inverted polarity checks that the inactive level flips.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ACT1  = 3'd1,
    PH_INACT = 3'd2,
    PH_WAIT  = 3'd3,
    PH_FIN   = 3'd4
  } phase_e;
endpackage

// File: rtl/spo_rst_sync.sv
module spo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/spo_ms_tick.sv
module spo_ms_tick #(
  parameter int unsigned CYC_PER_TICK = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (CYC_PER_TICK < 2) ? 1 : $clog2(CYC_PER_TICK);
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11: a tick is followed by a fresh count from zero
  a_r11_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/spo_phase_timer.sv
module spo_phase_timer #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // zero and one both end on the first tick
  assign expire_o = tick_i && (cnt_q <= DW'(1));
  assign cnt_en   = load_i || (tick_i && !expire_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/shutdown_pulse_seq.sv
module shutdown_pulse_seq
  import spo_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned DLY_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             act_high_i,
  input  logic             defer_oe_i,
  input  logic [DLY_W-1:0] dly_act_i,
  input  logic [DLY_W-1:0] dly_inact_i,
  input  logic [DLY_W-1:0] dly_wait_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int unsigned CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  logic             rst_int_n;
  logic             tick, expire, accept, t_load;
  logic [DLY_W-1:0] t_val;
  phase_e           phase_q, phase_d;
  logic             pol_q, pol_d;
  logic [DLY_W-1:0] dinact_q, dinact_d, dwait_q, dwait_d;
  logic             level_act, drive_active;

  spo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .srst_n_o(rst_int_n)
  );

  spo_ms_tick #(.CYC_PER_TICK(CYC_PER_MS)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (accept),
    .tick_o(tick)
  );

  spo_phase_timer #(.DW(DLY_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (t_load),
    .load_val_i(t_val),
    .tick_i    (tick),
    .expire_o  (expire)
  );

  assign accept = start_i && (phase_q == PH_IDLE);
  assign t_load = accept || (expire && (phase_q == PH_ACT1 || phase_q == PH_INACT));
  assign t_val  = accept ? dly_act_i : ((phase_q == PH_ACT1) ? dinact_q : dwait_q);

  // next-state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept) phase_d = PH_ACT1;
      PH_ACT1:  if (expire) phase_d = PH_INACT;
      PH_INACT: if (expire) phase_d = PH_WAIT;
      PH_WAIT:  if (expire) phase_d = PH_FIN;
      default:  phase_d = phase_q;
    endcase
  end

  always_comb begin
    pol_d    = accept ? act_high_i  : pol_q;
    dinact_d = accept ? dly_inact_i : dinact_q;
    dwait_d  = accept ? dly_wait_i  : dwait_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) phase_q <= PH_IDLE;
    else            phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pol_q    <= 1'b1;
      dinact_q <= '0;
      dwait_q  <= '0;
    end else if (accept) begin
      pol_q    <= pol_d;
      dinact_q <= dinact_d;
      dwait_q  <= dwait_d;
    end
  end

  // pad decode
  assign level_act    = (phase_q == PH_IDLE) ? act_high_i : pol_q;
  assign drive_active = (phase_q == PH_ACT1) || (phase_q == PH_WAIT) || (phase_q == PH_FIN);
  assign pad_o        = drive_active ? level_act : ~level_act;
  assign pad_oe_o     = (phase_q != PH_IDLE) || !defer_oe_i;
  assign busy_o       = (phase_q == PH_ACT1) || (phase_q == PH_INACT) || (phase_q == PH_WAIT);
  assign done_o       = (phase_q == PH_WAIT) || (phase_q == PH_FIN);
  assign timeout_o    = (phase_q == PH_FIN);

  // R3: a running sequence always drives the pad
  a_r3_busy_drives: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> pad_oe_o);
  // R9: busy only rises after a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> $past(start_i));
  // R9: timeout holds until reset
  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    timeout_o |=> timeout_o);
  // R6: timeout implies done and idle-free
  a_r6_timeout_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    timeout_o |-> (done_o && !busy_o && pad_oe_o));
  // R10: running phases only advance on a millisecond tick
  a_r10_advance_on_tick: assert property (@(posedge clk) disable iff (!rst_int_n)
    (($past(phase_q) != PH_IDLE) && (phase_q != $past(phase_q))) |-> $past(tick));
  // R5: each phase change while running flips the pad
  a_r5_edge_per_phase: assert property (@(posedge clk) disable iff (!rst_int_n)
    (($past(busy_o) && busy_o) && (phase_q != $past(phase_q))) |-> (pad_o != $past(pad_o)));
endmodule

// File: tb/shutdown_pulse_seq_tb.sv
`timescale 1ns/1ps
module shutdown_pulse_seq_tb;
  localparam int CLK_HZ = 8000;
  localparam int T      = CLK_HZ / 1000;
  localparam int DW     = 16;

  logic clk = 1'b0;
  logic rst_n, start_i, act_high_i, defer_oe_i;
  logic [DW-1:0] dly_act_i, dly_inact_i, dly_wait_i;
  logic pad_o, pad_oe_o, busy_o, done_o, timeout_o;

  always #4 clk = ~clk;

  shutdown_pulse_seq #(.CLK_HZ(CLK_HZ), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .act_high_i(act_high_i),
    .defer_oe_i(defer_oe_i), .dly_act_i(dly_act_i), .dly_inact_i(dly_inact_i),
    .dly_wait_i(dly_wait_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // behavioural reference: phase index and remaining cycles
  int   mph = 0;
  int   rem = 0;
  logic mpol = 1'b1;
  int   mdi = 0, mdw = 0;

  function automatic int len_of(input int d);
    return T * ((d == 0) ? 1 : d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mph = 0;
    else begin
      case (mph)
        0: if (start_i) begin
             mph = 1; rem = len_of(int'(dly_act_i)); mpol = act_high_i;
             mdi = int'(dly_inact_i); mdw = int'(dly_wait_i);
           end
        1: begin rem--; if (rem == 0) begin mph = 2; rem = len_of(mdi); end end
        2: begin rem--; if (rem == 0) begin mph = 3; rem = len_of(mdw); end end
        3: begin rem--; if (rem == 0) mph = 4; end
        default: ;
      endcase
    end
  end

  function automatic logic [4:0] model_out();
    logic act, drv;
    act = (mph == 0) ? act_high_i : mpol;
    drv = (mph == 1) || (mph == 3) || (mph == 4);
    return {drv ? act : ~act, (mph != 0) || !defer_oe_i,
            (mph >= 1 && mph <= 3), (mph >= 3), (mph == 4)};
  endfunction

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one cycle and compare all outputs with the model
  task automatic step();
    string tag;
    @(negedge clk);
    case (mph)
      0: tag = "R7 idle"; 1: tag = "R4 act1"; 2: tag = "R5 inact";
      3: tag = "R6 wait"; default: tag = "R9 final";
    endcase
    chk(tag, int'({pad_o, pad_oe_o, busy_o, done_o, timeout_o}), int'(model_out()));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; start_i = 1'b0; act_high_i = 1'b1; defer_oe_i = 1'b0;
    dly_act_i = 16'd3; dly_inact_i = 16'd2; dly_wait_i = 16'd4;
    repeat (3) step();
    chk("R1 reset outputs", int'({pad_o, pad_oe_o, busy_o, done_o, timeout_o}), 5'b01000);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", int'({pad_o, pad_oe_o, busy_o, done_o, timeout_o}), 5'b01000);

    // run 1: 3/2/4 ms, active high
    start_i = 1'b1; step(); start_i = 1'b0;
    chk("R3 active at once", int'({pad_o, pad_oe_o, busy_o}), 3'b111);
    n = 0;
    while (pad_o == 1'b1 && n < 2000) begin
      n++;
      if (n == 2) begin dly_inact_i = 16'd7; dly_wait_i = 16'd9; dly_act_i = 16'd1; end // R8
      start_i = (n == 5);                                                              // R9
      step();
    end
    start_i = 1'b0;
    chk("R4 R11 active length", n, 3 * T);
    n = 0;
    while (pad_o == 1'b0 && n < 2000) begin n++; step(); end
    chk("R5 R8 inactive length", n, 2 * T);
    chk("R5 done on re-activation", int'(done_o), 1);
    n = 0;
    while (timeout_o == 1'b0 && n < 2000) begin n++; step(); end
    chk("R6 R8 wait length", n, 4 * T);
    chk("R6 final outputs", int'({pad_o, pad_oe_o, busy_o, done_o}), 4'b1101);

    // R9: start after timeout is ignored
    start_i = 1'b1; step(); start_i = 1'b0;
    repeat (5) step();
    chk("R9 held after timeout", int'({pad_o, busy_o, timeout_o}), 3'b101);

    // second configuration: active low, deferred drive, zero delays
    rst_n = 1'b0; act_high_i = 1'b0; defer_oe_i = 1'b1;
    dly_act_i = '0; dly_inact_i = '0; dly_wait_i = '0;
    repeat (3) step();
    chk("R7 deferred enable low", int'(pad_oe_o), 0);
    chk("R2 inactive level high", int'(pad_o), 1);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R7 deferred idle", int'(pad_oe_o), 0);
    start_i = 1'b1; step(); start_i = 1'b0;
    chk("R2 R3 active low driven", int'({pad_o, pad_oe_o, busy_o}), 3'b011);
    act_high_i = 1'b1; // R8: polarity change mid-run
    n = 0;
    while (pad_o == 1'b0 && n < 2000) begin n++; step(); end
    chk("R10 zero active delay", n, T);
    n = 0;
    while (pad_o == 1'b1 && n < 2000) begin n++; step(); end
    chk("R10 zero inactive delay", n, T);
    n = 0;
    while (timeout_o == 1'b0 && n < 2000) begin n++; step(); end
    chk("R10 zero wait delay", n, T);
    chk("R8 polarity kept", int'(pad_o), 0);
    repeat (3) step();
    finish_up();
  end
endmodule